// File: doc/BRIEF.md
# Sixteen-bit integer ALU with per-operation status masking

This block is the execute stage of a small processor datapath. Each cycle in which `valid_in` is high, it takes a first operand, a second operand and an operation code. The second operand comes either from a register or from a short literal. The block computes one result and writes it into an output register on the next rising clock edge.

The block also holds the five-bit status register: carry, digit carry, negative, overflow and zero. Each operation has its own update mask. Only the flags in that mask take new values; the other flags keep their stored values. Add-with-carry and the two flag-to-bit copy operations read the stored status. A flag written by one operation is therefore visible to the next valid operation in the following cycle, with no bubble between them.

Instruction fetch, decoding of machine words, the register file and branching live outside the block.

Top module: `alu16_flagsel`

## Requirements
- R1: When `rst` is high at a rising edge, `result_o`, `status_o` and `valid_out` all read zero after that edge.
- R2: The second operand depends on `src_sel`. A value of 0 or 3 selects `b_in`. A value of 1 selects `lit_in[4:0]`, zero-extended. A value of 2 selects all of `lit_in`, zero-extended. The result and status of a valid operation appear after the next rising edge, and `valid_out` is high after that same edge.
- R3: `status_o` holds carry in bit 0, digit carry in bit 1, negative in bit 2, overflow in bit 3 and zero in bit 4. Op 0 (add) returns A+B modulo 2^16 and updates all five flags. Carry is the carry out of bit 15. Digit carry is the carry out of bit 3. Overflow is set when the two operands have equal signs and the result sign differs. Negative is result bit 15. Zero is set when the result is all zeros.
- R4: Op 1 (add with carry) returns A+B plus the stored carry. It updates the flags in the same way as R3.
- R5: Op 2 (AND) returns A&B. It updates only negative and zero; carry, digit carry and overflow keep their stored values.
- R6: Op 3 (arithmetic shift right by one) returns A shifted right by one place, with bit 15 kept. Carry takes the old A bit 0, overflow is cleared, and negative and zero are updated. Digit carry is unchanged.
- R7: Op 4 (variable arithmetic shift right) shifts A right by operand bits [3:0] and fills with the sign bit. It updates only negative and zero. An amount of 0 returns A unchanged, and an amount of 15 returns all copies of bit 15.
- R8: Ops 5, 6 and 7 set, clear or toggle the bit of A indexed by operand bits [3:0]. All status flags are unchanged.
- R9: Ops 8 and 9 return A with the bit indexed by operand bits [3:0] replaced by the stored carry (op 8) or the stored zero flag (op 9). All status flags are unchanged.
- R10: While `valid_in` is low, `result_o` and `status_o` hold their values and `valid_out` reads low after the edge.
- R11: Op codes 10 to 15 return A unchanged and leave all status flags unchanged.
- R12: A valid operation that reads status sees the flags written by the valid operation in the cycle immediately before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operation strobe |
| op_in | input | 4 | Operation code |
| src_sel | input | 2 | Second operand source select |
| a_in | input | 16 | First operand |
| b_in | input | 16 | Register second operand |
| lit_in | input | 10 | Literal second operand |
| result_o | output | 16 | Registered result |
| status_o | output | 5 | Status register {Z, OV, N, DC, C} |
| valid_out | output | 1 | High after the edge that captured a valid operation |

## Verification
Two things can fall on the same clock edge: the status write-back of one operation and the flag read of the next one. This happens, for example, when add produces a carry and add-with-carry consumes it, or when AND sets zero and a zero-to-bit copy follows. The bench provokes the overlap by issuing valid operations back to back with no idle cycle, both in directed pairs and in a long random stream. Its behavioural model carries the status from one operation to the next, so a stale or early flag read shows up as a result or status mismatch on the following clock.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_AND  = 4'd2,
    OP_ASR1 = 4'd3,
    OP_ASRV = 4'd4,
    OP_BSET = 4'd5,
    OP_BCLR = 4'd6,
    OP_BTGL = 4'd7,
    OP_BWRC = 4'd8,
    OP_BWRZ = 4'd9
  } alu_op_e;

  // Packed MSB first: z is bit 4, c is bit 0.
  typedef struct packed {
    logic z;
    logic ov;
    logic n;
    logic dc;
    logic c;
  } flags_t;

  localparam int FLAG_W = 5;

endpackage

// File: rtl/alu_src_mux.sv
module alu_src_mux #(
  parameter int W      = 16,
  parameter int LIT_W  = 10,
  parameter int SLIT_W = 5
) (
  input  logic [1:0]       src_sel,
  input  logic [W-1:0]     b_in,
  input  logic [LIT_W-1:0] lit_in,
  output logic [W-1:0]     b_op
);
  localparam int PAD_S = W - SLIT_W;
  localparam int PAD_L = W - LIT_W;

  always_comb begin
    unique case (src_sel)
      2'd1:    b_op = {{PAD_S{1'b0}}, lit_in[SLIT_W-1:0]};
      2'd2:    b_op = {{PAD_L{1'b0}}, lit_in};
      default: b_op = b_in;
    endcase
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         dc_out,
  output logic         ov_out
);
  logic [W:0] full;
  logic [4:0] low_nib;

  assign full    = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign low_nib = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, cin};
  assign sum     = full[W-1:0];
  assign c_out   = full[W];
  assign dc_out  = low_nib[4];
  assign ov_out  = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W    = 16,
  parameter int SH_W = 4
) (
  input  logic [W-1:0]    a,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    asr1,
  output logic            asr1_c,
  output logic [W-1:0]    asrv
);
  logic [W-1:0] stage [0:SH_W];

  assign asr1   = {a[W-1], a[W-1:1]};
  assign asr1_c = a[0];
  assign stage[0] = a;

  // Logarithmic barrel: stage s shifts by 2**s when amount bit s is set.
  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stage[s+1] = amt[s] ? {{D{a[W-1]}}, stage[s][W-1:D]} : stage[s];
  end

  assign asrv = stage[SH_W];
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu16_pkg::*;
#(
  parameter int W    = 16,
  parameter int SH_W = 4
) (
  input  logic [W-1:0]    a,
  input  logic [SH_W-1:0] idx,
  input  logic [3:0]      op,
  input  logic            c_in,
  input  logic            z_in,
  output logic [W-1:0]    y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic hit;
    assign hit = (idx == SH_W'(i));
    always_comb begin
      y[i] = a[i];
      if (hit) begin
        unique case (op)
          OP_BSET: y[i] = 1'b1;
          OP_BCLR: y[i] = 1'b0;
          OP_BTGL: y[i] = ~a[i];
          OP_BWRC: y[i] = c_in;
          OP_BWRZ: y[i] = z_in;
          default: y[i] = a[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/alu16_flagsel.sv
module alu16_flagsel
  import alu16_pkg::*;
#(
  parameter int W      = 16,
  parameter int LIT_W  = 10,
  parameter int SLIT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic [3:0]       op_in,
  input  logic [1:0]       src_sel,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     b_in,
  input  logic [LIT_W-1:0] lit_in,
  output logic [W-1:0]     result_o,
  output logic [4:0]       status_o,
  output logic             valid_out
);
  localparam int SH_W = $clog2(W);

  logic [W-1:0] b_op;
  logic [W-1:0] add_sum, asr1_r, asrv_r, bit_r, res_c, res_q;
  logic         add_c, add_dc, add_ov, asr1_c, cin;
  flags_t       cur, cand, upd, nxt;
  logic         vld_q;

  assign cur = flags_t'(status_o);
  assign cin = (op_in == OP_ADC) ? cur.c : 1'b0;

  alu_src_mux #(.W(W), .LIT_W(LIT_W), .SLIT_W(SLIT_W)) u_src (
    .src_sel (src_sel),
    .b_in    (b_in),
    .lit_in  (lit_in),
    .b_op    (b_op)
  );

  alu_adder #(.W(W)) u_add (
    .a      (a_in),
    .b      (b_op),
    .cin    (cin),
    .sum    (add_sum),
    .c_out  (add_c),
    .dc_out (add_dc),
    .ov_out (add_ov)
  );

  alu_shifter #(.W(W), .SH_W(SH_W)) u_shf (
    .a      (a_in),
    .amt    (b_op[SH_W-1:0]),
    .asr1   (asr1_r),
    .asr1_c (asr1_c),
    .asrv   (asrv_r)
  );

  alu_bitops #(.W(W), .SH_W(SH_W)) u_bit (
    .a    (a_in),
    .idx  (b_op[SH_W-1:0]),
    .op   (op_in),
    .c_in (cur.c),
    .z_in (cur.z),
    .y    (bit_r)
  );

  // Result select and per-operation flag mask.
  always_comb begin
    res_c = a_in;
    upd   = '0;
    cand  = cur;
    unique case (op_in)
      OP_ADD, OP_ADC: begin
        res_c   = add_sum;
        upd     = '1;
        cand.c  = add_c;
        cand.dc = add_dc;
        cand.ov = add_ov;
      end
      OP_AND: begin
        res_c  = a_in & b_op;
        upd.n  = 1'b1;
        upd.z  = 1'b1;
      end
      OP_ASR1: begin
        res_c   = asr1_r;
        upd.c   = 1'b1;
        upd.ov  = 1'b1;
        upd.n   = 1'b1;
        upd.z   = 1'b1;
        cand.c  = asr1_c;
        cand.ov = 1'b0;
      end
      OP_ASRV: begin
        res_c = asrv_r;
        upd.n = 1'b1;
        upd.z = 1'b1;
      end
      OP_BSET, OP_BCLR, OP_BTGL, OP_BWRC, OP_BWRZ: res_c = bit_r;
      default: res_c = a_in;
    endcase
    cand.n = res_c[W-1];
    cand.z = (res_c == '0);
    nxt    = flags_t'((cand & upd) | (cur & ~upd));
  end

  logic [4:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      stat_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= valid_in;
      if (valid_in) begin
        res_q  <= res_c;
        stat_q <= nxt;
      end
    end
  end

  assign result_o  = res_q;
  assign status_o  = stat_q;
  assign valid_out = vld_q;
endmodule

// File: rtl/alu16_flagsel_checker.sv
module alu16_flagsel_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_in,
  input logic [3:0]   op_in,
  input logic [1:0]   src_sel,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] result_o,
  input logic [4:0]   status_o,
  input logic         valid_out
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (status_o == 5'd0 && result_o == '0 && !valid_out));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);

  assert_add_sum_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op_in == 4'd0 && src_sel == 2'd0) |=>
      result_o == W'($past(a_in) + $past(b_in)));

  assert_and_keeps_c_dc_ov_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op_in == 4'd2) |=> $stable({status_o[3], status_o[1:0]}));

  assert_asr1_clears_ov_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op_in == 4'd3) |=> (!status_o[3] && $stable(status_o[1])));

  assert_asrv_keeps_c_dc_ov_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op_in == 4'd4) |=> $stable({status_o[3], status_o[1:0]}));

  assert_nz_track_result_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op_in <= 4'd4) |=>
      (status_o[4] == (result_o == '0) && status_o[2] == result_o[W-1]));

  assert_bitops_no_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op_in >= 4'd5 && op_in <= 4'd9) |=> $stable(status_o));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> ($stable(status_o) && $stable(result_o) && !valid_out));

  assert_unused_passes_a_R11: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op_in >= 4'd10) |=> (result_o == $past(a_in) && $stable(status_o)));
endmodule

bind alu16_flagsel alu16_flagsel_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid_in  (valid_in),
  .op_in     (op_in),
  .src_sel   (src_sel),
  .a_in      (a_in),
  .b_in      (b_in),
  .result_o  (result_o),
  .status_o  (status_o),
  .valid_out (valid_out)
);

// File: tb/alu16_flagsel_bench.sv
module alu16_flagsel_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [3:0]  op_in = '0;
  logic [1:0]  src_sel = '0;
  logic [15:0] a_in = '0, b_in = '0;
  logic [9:0]  lit_in = '0;
  logic [15:0] result_o;
  logic [4:0]  status_o;
  logic        valid_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] exp_res = '0;
  logic [4:0]  exp_st = '0;
  logic        exp_vld = 1'b0;
  string       tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_flagsel u_alu16_flagsel (
    .clk(clk), .rst(rst), .valid_in(valid_in), .op_in(op_in), .src_sel(src_sel),
    .a_in(a_in), .b_in(b_in), .lit_in(lit_in),
    .result_o(result_o), .status_o(status_o), .valid_out(valid_out)
  );

  // Behavioural reference: status bits {Z,OV,N,DC,C}.
  function automatic void model(input int op, input logic [15:0] a, input logic [15:0] b,
                                input logic [4:0] st, output logic [15:0] r,
                                output logic [4:0] ns);
    int s;
    int cin;
    int amt;
    int idx;
    ns = st;
    r = a;
    idx = b & 15;
    case (op)
      0, 1: begin
        cin = (op == 1) ? int'(st[0]) : 0;
        s = int'(a) + int'(b) + cin;
        r = s[15:0];
        ns[0] = s[16];
        ns[1] = (((a & 15) + (b & 15) + cin) >= 16);
        ns[3] = (a[15] == b[15]) && (r[15] != a[15]);
      end
      2: r = a & b;
      3: begin
        r = {a[15], a[15:1]};
        ns[0] = a[0];
        ns[3] = 1'b0;
      end
      4: begin
        amt = idx;
        r = a;
        for (int k = 0; k < amt; k++) r = {r[15], r[15:1]};
      end
      5: r[idx] = 1'b1;
      6: r[idx] = 1'b0;
      7: r[idx] = ~a[idx];
      8: r[idx] = st[0];
      9: r[idx] = st[4];
      default: r = a;
    endcase
    if (op <= 4) begin
      ns[2] = r[15];
      ns[4] = (r == 16'h0);
    end
  endfunction

  task automatic compare();
    checks += 3;
    if (result_o !== exp_res) begin
      errors++;
      $display("FAIL %s result got %h expected %h", tag, result_o, exp_res);
    end
    if (status_o !== exp_st) begin
      errors++;
      $display("FAIL %s status got %b expected %b", tag, status_o, exp_st);
    end
    if (valid_out !== exp_vld) begin
      errors++;
      $display("FAIL %s valid_out got %b expected %b", tag, valid_out, exp_vld);
    end
  endtask

  // Check the previous step's outcome, then drive the next one.
  task automatic step(input string t, input logic v, input int op, input int src,
                      input logic [15:0] a, input logic [15:0] b, input logic [9:0] lit);
    logic [15:0] bop;
    logic [15:0] r;
    logic [4:0]  ns;
    @(negedge clk);
    compare();
    tag = t;
    rst = 1'b0;
    valid_in = v;
    op_in = op[3:0];
    src_sel = src[1:0];
    a_in = a;
    b_in = b;
    lit_in = lit;
    bop = (src == 1) ? {11'b0, lit[4:0]} : (src == 2) ? {6'b0, lit} : b;
    if (v) begin
      model(op, a, bop, exp_st, r, ns);
      exp_res = r;
      exp_st = ns;
      exp_vld = 1'b1;
    end else begin
      exp_vld = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    compare();
    rst = 1'b1;
    valid_in = 1'b0;
    tag = "R1";
    exp_res = '0;
    exp_st = '0;
    exp_vld = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state.
    repeat (2) @(negedge clk);
    compare();
    // R3: 0x7FFF + 1 overflows into negative.
    step("R3", 1, 0, 0, 16'h7FFF, 16'h0001, 10'h0);
    // R3: 0xFFFF + 1 wraps to zero with carry and digit carry.
    step("R3", 1, 0, 0, 16'hFFFF, 16'h0001, 10'h0);
    // R4 R12: carry consumed back to back.
    step("R12", 1, 1, 0, 16'h00FF, 16'h0000, 10'h0);
    step("R4", 1, 1, 0, 16'hFFFF, 16'h0000, 10'h0);
    step("R4", 1, 1, 0, 16'h1234, 16'h0001, 10'h0);
    // R2: literal sources, upper literal bits must be dropped for src 1.
    step("R2", 1, 0, 1, 16'h1000, 16'hAAAA, 10'h3FF);
    step("R2", 1, 0, 2, 16'h1000, 16'hAAAA, 10'h3FF);
    step("R2", 1, 0, 3, 16'h1000, 16'h0101, 10'h3FF);
    // R5: AND keeps C/DC/OV.
    step("R5", 1, 0, 0, 16'h8000, 16'h8000, 10'h0);
    step("R5", 1, 2, 0, 16'hF0F0, 16'h0F0F, 10'h0);
    // R9 R12: zero flag written into a bit right after AND.
    step("R9", 1, 9, 1, 16'h0000, 16'h0, 10'd7);
    step("R9", 1, 8, 1, 16'hFFFF, 16'h0, 10'd15);
    // R6: single shift.
    step("R6", 1, 3, 0, 16'h8001, 16'h0, 10'h0);
    step("R6", 1, 3, 0, 16'h0001, 16'h0, 10'h0);
    // R7: shift by 0, by 15, by literal.
    step("R7", 1, 4, 0, 16'h8421, 16'h0000, 10'h0);
    step("R7", 1, 4, 0, 16'h8000, 16'h000F, 10'h0);
    step("R7", 1, 4, 1, 16'h4000, 16'h0, 10'h1F);
    step("R7", 1, 4, 0, 16'h7FFF, 16'hFFF3, 10'h0);
    // R8: bit set / clear / toggle.
    step("R8", 1, 5, 1, 16'h0000, 16'h0, 10'd15);
    step("R8", 1, 6, 0, 16'hFFFF, 16'd3, 10'h0);
    step("R8", 1, 7, 2, 16'h0F00, 16'h0, 10'd8);
    // R10: idle cycles with busy inputs.
    step("R10", 0, 0, 0, 16'hFFFF, 16'hFFFF, 10'h0);
    step("R10", 0, 3, 0, 16'h0001, 16'h0, 10'h0);
    // R11: unused codes.
    step("R11", 1, 10, 0, 16'hBEEF, 16'h1, 10'h0);
    step("R11", 1, 15, 0, 16'h0000, 16'h1, 10'h0);
    // R1: reset in mid-run.
    step("R1", 1, 0, 0, 16'hFFFF, 16'hFFFF, 10'h0);
    do_reset();
    step("R1", 0, 0, 0, 16'h0, 16'h0, 10'h0);
    // Random stream, back-to-back valid operations.
    for (int i = 0; i < 600; i++) begin
      int op;
      int sel;
      logic [15:0] a;
      logic [15:0] b;
      op = $urandom_range(0, 11);
      sel = $urandom_range(0, 3);
      a = 16'($urandom);
      b = 16'($urandom);
      if ($urandom_range(0, 7) == 0) a = 16'hFFFF;
      if ($urandom_range(0, 7) == 0) b = 16'h0001;
      step((op <= 1) ? "R12" : "R2", ($urandom_range(0, 4) != 0), op, sel, a, b,
           10'($urandom));
    end
    step("R10", 0, 0, 0, 16'h0, 16'h0, 10'h0);
    @(negedge clk);
    compare();
    finish_run();
  end
endmodule